// File: doc/BRIEF.md
# SMBus Timeout and Bus Idle Monitor

This block watches the synchronised SCL and SDA lines of an SMBus segment and measures time in baud clock ticks. Between a START and the following STOP it adds up the ticks during which SCL is held low. It raises a sticky flag when that total passes the controller limit, and another when it passes the target limit. It also raises a sticky flag when SCL stays high too long during a transfer.

The block also reports when the bus may be treated as idle. There are two such outputs. One shows that both lines have been high for the configured idle minimum. The other shows that both lines have been high long enough for the fairness wait that several controllers sharing the bus must observe.

The surrounding controller supplies START and STOP detections, a one-cycle baud tick enable and two packed configuration words. It clears the flags by pulsing the matching clear bits. The block does not release or reset the bus itself.

Top module: `smb_timeout_monitor`

## Requirements
- R1: During reset and on the first cycle after it, all five outputs are low.
- R2: Between START and STOP, `ctrl_to` sets once the count of SCL-low ticks reaches `to_cfg[23:16]` × 2048. A zero field never sets the flag.
- R3: Between START and STOP, `tgt_to` sets once the same SCL-low tick count reaches `to_cfg[15:8]` × 4096. A zero field never sets the flag.
- R4: During a transfer, `clkhi_to` sets once SCL has stayed high for `to_cfg[7:0]` × 8 ticks. Any cycle with SCL low restarts this count, and a zero field disables the flag.
- R5: A START or a STOP clears the cumulative count and the clock-high count. Outside a transfer neither count advances, so no timeout flag can rise two cycles after a START.
- R6: `bus_idle` is high once both lines have stayed high for `to_cfg[31:24]` ticks. That value is multiplied by 4 when bit 31 is set. A low line or any change on either line drops `bus_idle` on the next cycle.
- R7: `fair_ready` is high once the same high-line run reaches both `idle_cfg[31:16]` (fair delay) and `idle_cfg[15:0]` (fair idle minimum).
- R8: The timeout flags are sticky. `clr[0]`, `clr[1]` and `clr[2]` clear `ctrl_to`, `tgt_to` and `clkhi_to` respectively. A set condition in the same cycle wins over a clear.
- R9: The counts advance only in cycles where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Baud tick enable |
| scl | input | 1 | Synchronised clock line |
| sda | input | 1 | Synchronised data line |
| start_det | input | 1 | START (or repeated START) seen this cycle |
| stop_det | input | 1 | STOP seen this cycle |
| to_cfg | input | 32 | Idle minimum, controller, target and clock-high fields |
| idle_cfg | input | 32 | Fair delay [31:16], fair idle minimum [15:0] |
| clr | input | 3 | Write-1-to-clear pulses for the three flags |
| ctrl_to | output | 1 | Controller cumulative timeout flag |
| tgt_to | output | 1 | Target cumulative timeout flag |
| clkhi_to | output | 1 | Clock-high timeout flag |
| bus_idle | output | 1 | Idle minimum met |
| fair_ready | output | 1 | Fairness wait met |

## Verification
Some properties can be checked on every cycle, and the assertions cover these:
- a flag that is not cleared stays set;
- `bus_idle` and `fair_ready` only follow a cycle with both lines high;
- no cumulative flag rises just after a START;
- a clock-high flag only rises after SCL was high.

The exact thresholds need specific stimulus, so only the bench scenarios can show them. These scenarios cover the ×2048, ×4096 and ×8 scaling, the ×4 idle range bit, gating by `tick`, the zero-field disable and the set-over-clear priority. A behavioural reference model in the bench is compared with every output on every clock.

// File: rtl/smb_timeout_monitor.sv
module smb_timeout_monitor #(
  parameter int CUM_W  = 20,
  parameter int HI_W   = 11,
  parameter int IDLE_W = 17
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        scl,
  input  logic        sda,
  input  logic        start_det,
  input  logic        stop_det,
  input  logic [31:0] to_cfg,
  input  logic [31:0] idle_cfg,
  input  logic [2:0]  clr,
  output logic        ctrl_to,
  output logic        tgt_to,
  output logic        clkhi_to,
  output logic        bus_idle,
  output logic        fair_ready
);
  localparam logic [CUM_W-1:0]  CUM_MAX  = '1;
  localparam logic [HI_W-1:0]   HI_MAX   = '1;
  localparam logic [IDLE_W-1:0] IDLE_MAX = '1;

  logic              busy, scl_q, sda_q;
  logic [CUM_W-1:0]  cum;
  logic [HI_W-1:0]   hi_cnt;
  logic [IDLE_W-1:0] idle_cnt, idle_nxt;

  logic [CUM_W-1:0]  ctrl_lim, tgt_lim;
  logic [HI_W-1:0]   hi_lim;
  logic [IDLE_W-1:0] idle_lim, fair_lim;
  logic              frame_edge, restart;
  logic              ctrl_hit, tgt_hit, hi_hit;

  assign ctrl_lim = CUM_W'({to_cfg[23:16], 11'b0});
  assign tgt_lim  = CUM_W'({to_cfg[15:8], 12'b0});
  assign hi_lim   = HI_W'({to_cfg[7:0], 3'b0});
  assign idle_lim = to_cfg[31] ? IDLE_W'({to_cfg[31:24], 2'b0}) : IDLE_W'(to_cfg[31:24]);
  assign fair_lim = (idle_cfg[31:16] > idle_cfg[15:0]) ? IDLE_W'(idle_cfg[31:16])
                                                       : IDLE_W'(idle_cfg[15:0]);

  assign frame_edge = start_det | stop_det;
  assign restart    = !scl || !sda || (scl != scl_q) || (sda != sda_q);
  assign idle_nxt   = restart ? '0 :
                      (tick && idle_cnt != IDLE_MAX) ? idle_cnt + 1'b1 : idle_cnt;

  assign ctrl_hit = busy && (ctrl_lim != '0) && (cum >= ctrl_lim);
  assign tgt_hit  = busy && (tgt_lim  != '0) && (cum >= tgt_lim);
  assign hi_hit   = busy && (hi_lim   != '0) && (hi_cnt >= hi_lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cum  <= '0;
      hi_cnt <= '0;
    end else begin
      busy <= start_det ? 1'b1 : (stop_det ? 1'b0 : busy);
      if (frame_edge)
        cum <= '0;
      else if (busy && tick && !scl && cum != CUM_MAX)
        cum <= cum + 1'b1;
      if (frame_edge || !scl)
        hi_cnt <= '0;
      else if (busy && tick && hi_cnt != HI_MAX)
        hi_cnt <= hi_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_to  <= 1'b0;
      tgt_to   <= 1'b0;
      clkhi_to <= 1'b0;
    end else begin
      ctrl_to  <= ctrl_hit | (ctrl_to  & ~clr[0]);
      tgt_to   <= tgt_hit  | (tgt_to   & ~clr[1]);
      clkhi_to <= hi_hit   | (clkhi_to & ~clr[2]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      idle_cnt   <= '0;
      bus_idle   <= 1'b0;
      fair_ready <= 1'b0;
    end else begin
      scl_q      <= scl;
      sda_q      <= sda;
      idle_cnt   <= idle_nxt;
      bus_idle   <= !restart && (idle_nxt >= idle_lim);
      fair_ready <= !restart && (idle_nxt >= fair_lim);
    end
  end
endmodule

module smb_timeout_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl,
  input logic       sda,
  input logic       start_det,
  input logic [2:0] clr,
  input logic       ctrl_to,
  input logic       tgt_to,
  input logic       clkhi_to,
  input logic       bus_idle,
  input logic       fair_ready
);
  AST_CTRL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ctrl_to && !clr[0] |=> ctrl_to); // R8
  AST_TGT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) tgt_to && !clr[1] |=> tgt_to); // R8
  AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_idle) |-> $past(scl && sda)); // R6
  AST_FAIR_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n) $rose(fair_ready) |-> $past(scl && sda)); // R7
  AST_NO_RISE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) start_det |-> ##2 !$rose(ctrl_to) && !$rose(tgt_to)); // R5
  AST_CLKHI_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n) $rose(clkhi_to) |-> $past(scl, 2)); // R4
endmodule

bind smb_timeout_monitor smb_timeout_monitor_chk chk_i (.*);

// File: tb/smb_timeout_monitor_tb_top.sv
`timescale 1ns/1ps
module smb_timeout_monitor_tb_top;
  logic clk = 0, rst_n = 0, tick = 1, scl = 1, sda = 1, start_det = 0, stop_det = 0;
  logic [31:0] to_cfg = {8'd5, 8'd1, 8'd1, 8'd2};
  logic [31:0] idle_cfg = {16'd20, 16'd12};
  logic [2:0] clr = 0;
  logic ctrl_to, tgt_to, clkhi_to, bus_idle, fair_ready;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  smb_timeout_monitor dut_i (.*);

  // behavioural reference
  int m_cum, m_hi, m_idle;
  bit m_busy, m_sclq, m_sdaq, m_c, m_t, m_h, m_bi, m_fr;
  always @(posedge clk) begin
    int cl, tl, hl, il, fl, nxt;
    bit rs;
    if (!rst_n) begin
      m_cum = 0; m_hi = 0; m_idle = 0; m_busy = 0; m_sclq = 1; m_sdaq = 1;
      m_c = 0; m_t = 0; m_h = 0; m_bi = 0; m_fr = 0;
    end else begin
      cl = int'(to_cfg[23:16]) * 2048;
      tl = int'(to_cfg[15:8]) * 4096;
      hl = int'(to_cfg[7:0]) * 8;
      il = int'(to_cfg[31:24]) * (to_cfg[31] ? 4 : 1);
      fl = int'(idle_cfg[31:16]) > int'(idle_cfg[15:0]) ? int'(idle_cfg[31:16]) : int'(idle_cfg[15:0]);
      m_c = (m_busy && cl != 0 && m_cum >= cl) || (m_c && !clr[0]);
      m_t = (m_busy && tl != 0 && m_cum >= tl) || (m_t && !clr[1]);
      m_h = (m_busy && hl != 0 && m_hi >= hl) || (m_h && !clr[2]);
      rs = !scl || !sda || scl != m_sclq || sda != m_sdaq;
      nxt = rs ? 0 : (tick && m_idle < 131071) ? m_idle + 1 : m_idle;
      m_bi = !rs && nxt >= il;
      m_fr = !rs && nxt >= fl;
      m_idle = nxt;
      m_sclq = scl; m_sdaq = sda;
      if (start_det || stop_det) m_cum = 0;
      else if (m_busy && tick && !scl && m_cum < 1048575) m_cum++;
      if (start_det || stop_det || !scl) m_hi = 0;
      else if (m_busy && tick && m_hi < 2047) m_hi++;
      m_busy = start_det ? 1'b1 : (stop_det ? 1'b0 : m_busy);
    end
  end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R2 ctrl_to", ctrl_to, m_c);
      chk("R3 tgt_to", tgt_to, m_t);
      chk("R4 clkhi_to", clkhi_to, m_h);
      chk("R6 bus_idle", bus_idle, m_bi);
      chk("R7 fair_ready", fair_ready, m_fr);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_det = 1; cyc(1); start_det = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    cyc(3);
    chk("R1 reset ctrl_to", ctrl_to, 0);
    chk("R1 reset bus_idle", bus_idle, 0);
    rst_n = 1;
    cyc(1);
    chk("R1 after reset", ctrl_to | tgt_to | clkhi_to | bus_idle | fair_ready, 0);
    cyc(30);
    chk("R6 idle after run", bus_idle, 1);
    chk("R7 fair after run", fair_ready, 1);
    sda = 0; cyc(1); sda = 1; cyc(2);
    chk("R6 idle drops on edge", bus_idle, 0);
    to_cfg[31:24] = 8'h82;
    for (int i = 0; i < 700; i++) begin tick = i[0]; cyc(1); end
    chk("R9 idle not yet with half-rate tick", bus_idle, 0);
    for (int i = 0; i < 400; i++) begin tick = i[0]; cyc(1); end
    chk("R6 idle after x4 range", bus_idle, 1);
    tick = 1;
    to_cfg[31:24] = 8'd5;
    pulse_start();
    scl = 0; sda = 0;
    cyc(2100);
    chk("R2 ctrl set", ctrl_to, 1);
    chk("R3 tgt not yet", tgt_to, 0);
    cyc(2100);
    chk("R3 tgt set", tgt_to, 1);
    clr = 3'b001; cyc(1); clr = 0; cyc(1);
    chk("R8 ctrl still set, set wins over clear", ctrl_to, 1);
    scl = 1; cyc(1); scl = 0; cyc(1); scl = 1;
    cyc(20);
    chk("R4 clkhi set", clkhi_to, 1);
    scl = 1; sda = 1; stop_det = 1; cyc(1); stop_det = 0;
    cyc(2);
    clr = 3'b111; cyc(1); clr = 0; cyc(1);
    chk("R8 ctrl cleared", ctrl_to, 0);
    chk("R8 tgt cleared", tgt_to, 0);
    chk("R8 clkhi cleared", clkhi_to, 0);
    pulse_start();
    scl = 0; cyc(1000);
    stop_det = 1; cyc(1); stop_det = 0;
    pulse_start(); cyc(1100);
    chk("R5 count restarted", ctrl_to, 0);
    to_cfg[23:16] = 0;
    cyc(2100);
    chk("R2 zero field disabled", ctrl_to, 0);
    scl = 1; sda = 1; stop_det = 1; cyc(1); stop_det = 0;
    cyc(5);
    finish_run();
  end
endmodule